// File: doc/BRIEF.md
# Receive Security Association Table Access Block

This block holds the three receive-side security association tables of a network offload engine and gives software indirect access to them through a small 32-bit register bus. Software fills staging registers first: four address words, an SPI word, an address-table pointer, four key words, a salt word and a mode word. It then writes one command register. That register names a table and an entry and carries a write or read strobe.

A write strobe copies the staged fields for the chosen table into the chosen entry. A read strobe copies the entry back into the staging registers, where software reads it on its next bus access. The same command register also holds the global lookup enable, which the packet path uses. Table storage has no reset, so entries survive a block reset. Software is expected to clear the tables itself.

Top module: `sa_table_regs`

## Requirements
- R1: After reset, every register address reads zero and `lookup_en` is low.
- R2: The staging registers are at word addresses 1-4 (address words 0..3), 5 (SPI), 6 (address-table pointer), 7-10 (key words 0..3), 11 (salt) and 12 (mode). Each reads back what was last written to it. The pointer keeps only its low 7 bits and reads back zero-extended.
- R3: The command register is at address 0. It has the lookup enable in bit 0, the table selector in bits 2:1, the entry index in bits 12:3, the read strobe in bit 30 and the write strobe in bit 31. It reads back the enable, selector and index, with bits 31:30 and the other bits always zero. `lookup_en` follows bit 0 from the cycle after the write.
- R4: A write strobe with selector 1 stores the four address words as a 128-bit entry of the 128-entry address table.
- R5: A write strobe with selector 2 stores the SPI and the 7-bit pointer into the 1024-entry SPI table.
- R6: A write strobe with selector 3 stores the four key words, the salt and the mode word into the 1024-entry key table. In the mode word, bit 0 is valid, bit 2 is ESP, bit 3 is decrypt and bit 4 is IPv6.
- R7: A read strobe copies the selected entry into the matching staging registers one cycle after the command write, so the values are visible on the next bus read.
- R8: For the address table, an index of 128 or more is ignored. A write changes no entry, and a read leaves the staging registers unchanged.
- R9: A command with both strobes set acts as a write only and leaves the staging registers unchanged.
- R10: Writing zero to the command register clears `lookup_en` and leaves all table contents intact. Selector 0 performs no table operation.
- R11: Table contents are kept across a reset.
- R12: A command is executed exactly once. Staging writes made after it do not reach the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset for the control and staging registers |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| lookup_en | output | 1 | Global lookup enable |

## Verification
The hardest cases to reach from the ports are the ones where a faulty design leaves no visible trace. One is a command that acts twice. Another is a read that sneaks in beside a write. A third is an out-of-range address index that aliases onto a low entry. The bench reaches each one in three steps. It first writes a known entry. It then loads different staging values and issues the suspect command. Finally it reads the original entry back, so any second execution, stray read or aliased write shows up as changed data. Random writes spread over all three tables, with read-back from a pool of recently written indexes, cover the rest of the address space. A reset is applied in the middle of the run to show that the stored entries persist.

// File: rtl/sa_table_regs.sv
module sa_table_regs #(
  parameter int SA_ENTRIES = 1024,
  parameter int IP_ENTRIES = 128,
  parameter int ADDR_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              lookup_en
);
  localparam int SA_IW = $clog2(SA_ENTRIES);
  localparam int IP_IW = $clog2(IP_ENTRIES);
  localparam int A_CMD = 0, A_IP0 = 1, A_SPI = 5, A_PTR = 6, A_KEY0 = 7, A_SALT = 11, A_MODE = 12;
  localparam logic [1:0] SEL_IP = 2'd1, SEL_SPI = 2'd2, SEL_KEY = 2'd3;

  logic              en_q;
  logic [1:0]        sel_q;
  logic [9:0]        idx_q;
  logic              do_wr, do_rd;
  logic [3:0][31:0]  ip_q, key_q;
  logic [31:0]       spi_q, salt_q, mode_q;
  logic [IP_IW-1:0]  ptr_q;

  logic [127:0]      ip_mem   [IP_ENTRIES];
  logic [31:0]       spi_mem  [SA_ENTRIES];
  logic [IP_IW-1:0]  ptr_mem  [SA_ENTRIES];
  logic [127:0]      key_mem  [SA_ENTRIES];
  logic [31:0]       salt_mem [SA_ENTRIES];
  logic [31:0]       mode_mem [SA_ENTRIES];

  wire cmd_hit = reg_wr && (reg_addr == ADDR_W'(A_CMD));
  wire ip_ok   = ({22'b0, idx_q} < 32'(IP_ENTRIES));
  wire sa_ok   = ({22'b0, idx_q} < 32'(SA_ENTRIES));
  wire [IP_IW-1:0] ip_a = idx_q[IP_IW-1:0];
  wire [SA_IW-1:0] sa_a = idx_q[SA_IW-1:0];

  assign lookup_en = en_q;

  always_ff @(posedge clk) begin
    if (do_wr && sel_q == SEL_IP && ip_ok)
      ip_mem[ip_a] <= ip_q;
    if (do_wr && sel_q == SEL_SPI && sa_ok) begin
      spi_mem[sa_a] <= spi_q;
      ptr_mem[sa_a] <= ptr_q;
    end
    if (do_wr && sel_q == SEL_KEY && sa_ok) begin
      key_mem[sa_a]  <= key_q;
      salt_mem[sa_a] <= salt_q;
      mode_mem[sa_a] <= mode_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      sel_q <= '0;
      idx_q <= '0;
      do_wr <= 1'b0;
      do_rd <= 1'b0;
    end else begin
      do_wr <= cmd_hit && reg_wdata[31];
      do_rd <= cmd_hit && reg_wdata[30] && !reg_wdata[31];
      if (cmd_hit) begin
        en_q  <= reg_wdata[0];
        sel_q <= reg_wdata[2:1];
        idx_q <= reg_wdata[12:3];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ip_q   <= '0;
      key_q  <= '0;
      spi_q  <= '0;
      salt_q <= '0;
      mode_q <= '0;
      ptr_q  <= '0;
    end else begin
      if (reg_wr) begin
        for (int i = 0; i < 4; i++) begin
          if (reg_addr == ADDR_W'(A_IP0 + i))  ip_q[i]  <= reg_wdata;
          if (reg_addr == ADDR_W'(A_KEY0 + i)) key_q[i] <= reg_wdata;
        end
        if (reg_addr == ADDR_W'(A_SPI))  spi_q  <= reg_wdata;
        if (reg_addr == ADDR_W'(A_PTR))  ptr_q  <= reg_wdata[IP_IW-1:0];
        if (reg_addr == ADDR_W'(A_SALT)) salt_q <= reg_wdata;
        if (reg_addr == ADDR_W'(A_MODE)) mode_q <= reg_wdata;
      end
      if (do_rd) begin
        case (sel_q)
          SEL_IP:  if (ip_ok) ip_q <= ip_mem[ip_a];
          SEL_SPI: if (sa_ok) begin
            spi_q <= spi_mem[sa_a];
            ptr_q <= ptr_mem[sa_a];
          end
          SEL_KEY: if (sa_ok) begin
            key_q  <= key_mem[sa_a];
            salt_q <= salt_mem[sa_a];
            mode_q <= mode_mem[sa_a];
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_W'(A_CMD):    reg_rdata = {19'b0, idx_q, sel_q, en_q};
      ADDR_W'(A_IP0):    reg_rdata = ip_q[0];
      ADDR_W'(A_IP0+1):  reg_rdata = ip_q[1];
      ADDR_W'(A_IP0+2):  reg_rdata = ip_q[2];
      ADDR_W'(A_IP0+3):  reg_rdata = ip_q[3];
      ADDR_W'(A_SPI):    reg_rdata = spi_q;
      ADDR_W'(A_PTR):    reg_rdata = 32'(ptr_q);
      ADDR_W'(A_KEY0):   reg_rdata = key_q[0];
      ADDR_W'(A_KEY0+1): reg_rdata = key_q[1];
      ADDR_W'(A_KEY0+2): reg_rdata = key_q[2];
      ADDR_W'(A_KEY0+3): reg_rdata = key_q[3];
      ADDR_W'(A_SALT):   reg_rdata = salt_q;
      ADDR_W'(A_MODE):   reg_rdata = mode_q;
      default:           reg_rdata = '0;
    endcase
  end
endmodule

module sa_table_regs_chk #(parameter int ADDR_W = 4) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic [31:0]       reg_rdata,
  input logic              lookup_en,
  input logic              do_wr,
  input logic              do_rd,
  input logic [31:0]       spi_q
);
  // R3
  en_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == '0) |=> lookup_en == $past(reg_wdata[0]));
  // R3
  strobe_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == '0) |-> reg_rdata[31:30] == 2'b00);
  // R12
  wr_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_wr |-> $past(reg_wr && reg_addr == '0 && reg_wdata[31]));
  // R9
  rd_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_rd |-> $past(reg_wr && reg_addr == '0 && reg_wdata[30] && !reg_wdata[31]));
  // R2
  staging_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr && !do_rd) |=> $stable(spi_q));
endmodule

bind sa_table_regs sa_table_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lookup_en(lookup_en),
  .do_wr(do_wr), .do_rd(do_rd), .spi_q(spi_q)
);

// File: tb/sa_table_regs_tb.sv
module sa_table_regs_tb;
  localparam int SAN = 1024, IPN = 128;

  logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic lookup_en;
  int checks = 0, errors = 0;
  bit done = 0;

  sa_table_regs u_dut (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lookup_en(lookup_en));

  always #10 clk = ~clk;

  logic [127:0] m_ip [IPN];
  logic [31:0]  m_spi [SAN];
  logic [6:0]   m_ptr [SAN];
  logic [127:0] m_key [SAN];
  logic [31:0]  m_salt [SAN], m_mode [SAN];
  int pool [4][16];
  int pcnt [4];

  function automatic logic [31:0] cmd(input int sel, input int idx, input bit en, input bit w, input bit r);
    return {w, r, 17'b0, idx[9:0], sel[1:0], en};
  endfunction

  function automatic logic [127:0] r128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a[3:0]; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk); reg_addr = a[3:0]; #1 d = reg_rdata;
  endtask

  task automatic put_ip(input int idx, input logic [127:0] v, input bit model);
    for (int i = 0; i < 4; i++) wr(1 + i, v[32*i +: 32]);
    wr(0, cmd(1, idx, 1, 1, 0));
    if (model) m_ip[idx] = v;
  endtask

  task automatic put_spi(input int idx, input logic [31:0] s, input logic [6:0] p);
    wr(5, s); wr(6, 32'(p));
    wr(0, cmd(2, idx, 1, 1, 0));
    m_spi[idx] = s; m_ptr[idx] = p;
  endtask

  task automatic put_key(input int idx, input logic [127:0] k, input logic [31:0] s, input logic [31:0] m);
    for (int i = 0; i < 4; i++) wr(7 + i, k[32*i +: 32]);
    wr(11, s); wr(12, m);
    wr(0, cmd(3, idx, 1, 1, 0));
    m_key[idx] = k; m_salt[idx] = s; m_mode[idx] = m;
  endtask

  task automatic get_ip(input int idx, input string req);
    logic [31:0] d;
    wr(0, cmd(1, idx, 1, 0, 1));
    for (int i = 0; i < 4; i++) begin rd(1 + i, d); chk(req, d, m_ip[idx][32*i +: 32]); end
  endtask

  task automatic get_spi(input int idx, input string req);
    logic [31:0] d;
    wr(0, cmd(2, idx, 1, 0, 1));
    rd(5, d); chk(req, d, m_spi[idx]);
    rd(6, d); chk(req, d, 32'(m_ptr[idx]));
  endtask

  task automatic get_key(input int idx, input string req);
    logic [31:0] d;
    wr(0, cmd(3, idx, 1, 0, 1));
    for (int i = 0; i < 4; i++) begin rd(7 + i, d); chk(req, d, m_key[idx][32*i +: 32]); end
    rd(11, d); chk(req, d, m_salt[idx]);
    rd(12, d); chk(req, d, m_mode[idx]);
  endtask

  task automatic remember(input int t, input int idx);
    pool[t][pcnt[t] % 16] = idx;
    pcnt[t]++;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, v;
    logic [127:0] a, b;
    void'($urandom(32'h5A17));
    for (int t = 0; t < 4; t++) pcnt[t] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int i = 0; i < 13; i++) begin rd(i, d); chk("R1", d, 32'h0); end
    chk("R1 lookup_en", 32'(lookup_en), 32'h0);

    // R2 staging read-back
    for (int i = 1; i < 13; i++) begin
      v = $urandom;
      wr(i, v); rd(i, d);
      chk("R2", d, (i == 6) ? (v & 32'h7F) : v);
    end

    // R3 command fields, R10 selector 0 no-op
    wr(0, cmd(2, 'h2AB, 1, 0, 0));
    rd(0, d); chk("R3 fields", d, 32'h1 | (32'h2 << 1) | (32'h2AB << 3));
    chk("R3 lookup_en", 32'(lookup_en), 32'h1);
    wr(0, cmd(0, 'h155, 1, 1, 1));
    rd(0, d); chk("R3 strobes low", d, 32'h1 | (32'h155 << 3));

    // R4 R5 R6 R7 directed
    a = r128(); put_ip(5, a, 1); get_ip(5, "R4");
    put_spi(9, 32'hC0DE_0009, 7'h55); get_spi(9, "R5");
    put_key(1023, r128(), $urandom, 32'h1D); get_key(1023, "R6");

    // R8 address-table index out of range
    b = r128(); put_ip(128 + 5, b, 0); get_ip(5, "R8 write ignored");
    for (int i = 0; i < 4; i++) wr(1 + i, 32'hA5A5_0000 + i);
    wr(0, cmd(1, 133, 1, 0, 1));
    for (int i = 0; i < 4; i++) begin rd(1 + i, d); chk("R8 read ignored", d, 32'hA5A5_0000 + i); end

    // R9 both strobes act as write only
    wr(5, 32'h1111_2222); wr(6, 32'h33);
    wr(0, cmd(2, 9, 1, 1, 1));
    m_spi[9] = 32'h1111_2222; m_ptr[9] = 7'h33;
    rd(5, d); chk("R9 staging kept", d, 32'h1111_2222);
    wr(5, 32'hDEAD_BEEF);
    get_spi(9, "R9 table written");

    // R12 executes once
    put_spi(20, 32'hAAAA_0020, 7'h20);
    wr(5, 32'hBBBB_0020); wr(6, 32'h7F);
    repeat (4) @(negedge clk);
    get_spi(20, "R12");

    // random traffic over all tables, R4 R5 R6 R7
    for (int it = 0; it < 300; it++) begin
      int t, idx;
      t = 1 + int'($urandom % 3);
      idx = (t == 1) ? int'($urandom % IPN) : int'($urandom % SAN);
      case (t)
        1: put_ip(idx, r128(), 1);
        2: put_spi(idx, $urandom, 7'($urandom));
        default: put_key(idx, r128(), $urandom, $urandom & 32'h1D);
      endcase
      remember(t, idx);
      t = 1 + int'($urandom % 3);
      if (pcnt[t] > 0) begin
        idx = pool[t][$urandom % ((pcnt[t] < 16) ? pcnt[t] : 16)];
        case (t)
          1: get_ip(idx, "R7 ip");
          2: get_spi(idx, "R7 spi");
          default: get_key(idx, "R7 key");
        endcase
      end
    end

    // R10 zero command disables, contents kept
    wr(0, 32'h0);
    chk("R10 lookup_en", 32'(lookup_en), 32'h0);
    rd(0, d); chk("R10 cmd", d, 32'h0);
    get_spi(9, "R10 kept");

    // R11 tables survive reset
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    rd(5, d); chk("R11 staging cleared", d, 32'h0);
    get_ip(5, "R11 ip");
    get_key(1023, "R11 key");
    if (pcnt[2] > 0) get_spi(pool[2][0], "R11 spi");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule